// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Enable Controller

This block takes one reference clock and spreads it over a set of buffered clock outputs, eighteen by default. Each output has its own enable bit. A bus master writes those bits over a two-wire I2C link, where the block acts only as a write-only slave receiver. Inside the block the serial lines are oversampled on a faster system clock. The block finds START and STOP conditions, checks the address byte, and acknowledges each accepted byte by pulling SDA low. Accepted data bytes fill the enable registers strictly in order, and a new START always begins again at the first register. Nothing in the register bank can be read back.

Every enable bit comes out of reset set to 1, so all outputs run from the start. When an enable bit is cleared, its output is held low instead of toggling. A new enable value is accepted at the end of the acknowledge clock of its byte. It only reaches the output gate while the reference clock is low, which means no output pulse is ever cut short. A separate global enable pin controls the tri-state enable of every output pad together, and it overrides the per-output bits. The pads are modelled as a data value plus an enable.

Top module: `clkfan_i2c_ctl`

## Requirements
- R1: After reset every enable bit is 1, so every clk_out follows ref_clk.
- R2: An address byte equal to DEV_ADDR followed by a write bit (0) is acknowledged: sda_oe is high during the ninth SCL high phase.
- R3: An address byte with a different address, or with the read bit (1), is not acknowledged. The block then ignores the rest of that transaction and leaves the enables unchanged.
- R4: After an accepted address, data bytes are acknowledged and stored in order. The first byte goes to register 0, the second to register 1, the third to register 2.
- R5: Data bytes after the third one in a transaction are acknowledged and dropped.
- R6: An output whose enable bit is 0 stays low. An output whose enable bit is 1 copies ref_clk.
- R7: Output bit k is controlled by register k/8, bit k%8 (LSB first). Bits 7:2 of register 2 have no effect.
- R8: clk_out_en is all ones when oe_all is 1 and all zeros when oe_all is 0, whatever the enable bits are.
- R9: A repeated START sends the next data byte to register 0 again.
- R10: A STOP before a byte's acknowledge has finished leaves every register unchanged.
- R11: The gate applied to the outputs changes only while ref_clk is low.
- R12: sda_oe rises and falls only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample SCL/SDA |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C serial clock line |
| sda_i | input | 1 | I2C serial data line (value on the wire) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| oe_all | input | 1 | Global pad enable, 0 puts all outputs in high impedance |
| ref_clk | input | 1 | Reference clock to be distributed |
| clk_out | output | NUM_OUT | Gated output clocks (pad value) |
| clk_out_en | output | NUM_OUT | Pad tri-state enables |

## Verification
The bench keeps the default of eighteen outputs. That gives three registers, so bytes past the last register and the unused upper bits of register 2 can both be exercised. It changes DEV_ADDR to 7'h2A. With that address, flipping a single bit of the address produces near-miss addresses, and those are mixed into the random transactions with read requests, repeated STARTs and varying byte counts. The reference clock runs at one sixth of the system clock, so the bench can observe, within a few cycles, that gating updates wait for the low phase.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_DATA,
    ST_ACK_DATA
  } slv_state_t;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign q    = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_REG  = 3,
  localparam int unsigned IDX_W   = $clog2(NUM_REG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  slv_state_t        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              start_c, stop_c;

  assign start_c = scl_q & sda_fall;
  assign stop_c  = scl_q & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      idx     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        idx     <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_DATA) begin
                state  <= ST_ACK_DATA;
                sda_oe <= 1'b1;
              end else if (shreg == {DEV_ADDR, 1'b0}) begin
                state  <= ST_ACK_ADDR;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_ADDR, ST_ACK_DATA: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_DATA;
              if (state == ST_ACK_DATA && idx < IDX_W'(NUM_REG)) begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= shreg;
                idx     <= idx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/enable_bank.sv
module enable_bank
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = 18,
  localparam int unsigned NUM_REG = (NUM_OUT + BYTE_W - 1) / BYTE_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REG + 1),
  localparam int unsigned BANK_W  = NUM_REG * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NUM_OUT-1:0] en_vec
);
  logic [BANK_W-1:0] bank;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               bank[r*BYTE_W +: BYTE_W] <= '1;
      else if (wr_en && wr_idx == IDX_W'(r))    bank[r*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  assign en_vec = bank[NUM_OUT-1:0];

  if (BANK_W > NUM_OUT) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^bank[BANK_W-1:NUM_OUT];
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int unsigned NUM_OUT = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk,
  input  logic               oe_all,
  input  logic [NUM_OUT-1:0] en_req,
  output logic [NUM_OUT-1:0] gate_q,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_en
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gate_q[i] <= 1'b1;
      else if (!ref_clk) gate_q[i] <= en_req[i];
    end
    assign clk_out[i]    = ref_clk & gate_q[i];
    assign clk_out_en[i] = oe_all;
  end
endmodule

// File: rtl/clkfan_i2c_ctl.sv
module clkfan_i2c_ctl
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_OUT  = 18,
  localparam int unsigned NUM_REG = (NUM_OUT + BYTE_W - 1) / BYTE_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               oe_all,
  input  logic               ref_clk,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_en
);
  logic scl_q, scl_rise, scl_fall;
  logic sda_q, sda_rise, sda_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_OUT-1:0] en_vec;
  logic [NUM_OUT-1:0] gate_vec;

  pin_sync #(.STAGES(2)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i),
    .q(scl_q), .rise(scl_rise), .fall(scl_fall)
  );

  pin_sync #(.STAGES(2)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i),
    .q(sda_q), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_wr_slave #(.DEV_ADDR(DEV_ADDR), .NUM_REG(NUM_REG)) u_slv (
    .clk(clk), .rst_n(rst_n),
    .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  enable_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .en_vec(en_vec)
  );

  clk_gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .oe_all(oe_all),
    .en_req(en_vec), .gate_q(gate_vec),
    .clk_out(clk_out), .clk_out_en(clk_out_en)
  );
endmodule

// File: rtl/clkfan_i2c_chk.sv
module clkfan_i2c_chk #(
  parameter int unsigned NUM_OUT = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic               ref_clk,
  input logic [NUM_OUT-1:0] gate_vec,
  input logic [NUM_OUT-1:0] clk_out
);
  assert_gate_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_clk) |-> $stable(gate_vec));

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~gate_vec) == '0);

  assert_ack_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_ack_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
endmodule

bind clkfan_i2c_ctl clkfan_i2c_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .ref_clk(ref_clk), .gate_vec(gate_vec), .clk_out(clk_out)
);

// File: tb/sim_clkfan_i2c_ctl.sv
`timescale 1ns/1ps
module sim_clkfan_i2c_ctl;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int NOUT = 18;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, oe_all = 1'b1, ref_clk = 1'b0;
  logic sda_oe, sda_line;
  logic [NOUT-1:0] clk_out, clk_out_en;
  logic [23:0] mreg;
  int checks = 0, errors = 0;
  bit done = 0;

  assign sda_line = sda_drv & ~sda_oe;

  clkfan_i2c_ctl #(.DEV_ADDR(ADDR), .NUM_OUT(NOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .oe_all(oe_all), .ref_clk(ref_clk), .clk_out(clk_out), .clk_out_en(clk_out_en)
  );

  always #2 clk = ~clk;
  always begin
    repeat (3) @(negedge clk);
    ref_clk = ~ref_clk;
  end

  function automatic logic [NOUT-1:0] exp_en(input logic [23:0] r);
    return r[NOUT-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic bit_w(input logic b);
    sda_drv = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic byte_w(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    ack = (sda_line == 1'b0);
    wq(); scl = 1'b0; wq();
  endtask

  // R6, R7, R8, R11: sample whole ref periods; high phase must carry the full pattern
  task automatic check_outputs(input string req);
    logic [NOUT-1:0] e;
    bit ok;
    logic [NOUT-1:0] bad;
    e = exp_en(mreg);
    repeat (20) @(negedge clk);
    ok = 1; bad = '0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      if (ref_clk && clk_out !== e)    begin ok = 0; bad = clk_out; end
      if (!ref_clk && clk_out !== '0)  begin ok = 0; bad = clk_out; end
    end
    chk(ok, {req, " clk_out"}, 32'(bad), 32'(e));
    chk(clk_out_en === {NOUT{oe_all}}, "R8 clk_out_en", 32'(clk_out_en), 32'({NOUT{oe_all}}));
  endtask

  // Write transaction with model update; checks acks per byte
  task automatic write_seq(input logic [6:0] a, input logic rw, input int nb, input bit rep);
    logic ack;
    bit match;
    int idx;
    logic [7:0] d;
    int segs;
    segs = rep ? 2 : 1;
    for (int s = 0; s < segs; s++) begin
      i2c_start();
      match = (a == ADDR) && (rw == 1'b0);
      byte_w({a, rw}, ack);
      if (match) chk(ack == 1'b1, "R2 address ack", 32'(ack), 32'd1);
      else       chk(ack == 1'b0, "R3 address nack", 32'(ack), 32'd0);
      if (!match) break;
      idx = 0;
      for (int n = 0; n < nb; n++) begin
        d = 8'($urandom);
        byte_w(d, ack);
        chk(ack == 1'b1, (idx < 3) ? "R4 data ack" : "R5 extra ack", 32'(ack), 32'd1);
        if (idx < 3) mreg[idx*8 +: 8] = d;
        idx++;
      end
    end
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [6:0] a;
    int sel;
    void'($urandom(32'd20240611));
    mreg = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_outputs("R1 reset");

    // R7 mapping directed
    i2c_start(); byte_w({ADDR, 1'b0}, ack);
    byte_w(8'h01, ack); byte_w(8'h80, ack); byte_w(8'hFE, ack);
    i2c_stop();
    mreg = 24'hFE_80_01;
    check_outputs("R7 mapping");
    chk(clk_out_en === '1, "R7 pads on", 32'(clk_out_en), 32'h3FFFF);

    // R8 global disable overrides
    oe_all = 1'b0;
    check_outputs("R8 oe low");
    oe_all = 1'b1;

    // R10 STOP mid-byte
    i2c_start(); byte_w({ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bit_w(1'b0);
    i2c_stop();
    check_outputs("R10 partial byte");

    // R9 repeated start goes back to register 0
    i2c_start(); byte_w({ADDR, 1'b0}, ack);
    byte_w(8'h11, ack); byte_w(8'h22, ack);
    i2c_start(); byte_w({ADDR, 1'b0}, ack);
    byte_w(8'h33, ack);
    i2c_stop();
    mreg[7:0] = 8'h33; mreg[15:8] = 8'h22;
    check_outputs("R9 restart");

    // R3 read request ignored
    i2c_start(); byte_w({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R3 read nack", 32'(ack), 32'd0);
    for (int i = 0; i < 8; i++) bit_w(1'b1);
    i2c_stop();
    check_outputs("R3 read ignored");

    // R5 extra bytes dropped
    write_seq(ADDR, 1'b0, 5, 1'b0);
    check_outputs("R5 extra bytes");

    // Constrained random
    for (int t = 0; t < 30; t++) begin
      sel = int'($urandom % 20);
      if (sel < 14)      a = ADDR;
      else if (sel < 17) a = ADDR ^ (7'd1 << ($urandom % 7));
      else               a = 7'($urandom);
      oe_all = ($urandom % 4) != 0;
      write_seq(a, ($urandom % 5) == 0, int'($urandom % 6), ($urandom % 4) == 0);
      check_outputs("R6 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule